// File: doc/BRIEF.md
# Receiver Operating Mode Controller

This block is the state machine that decides what the digital back end of a radio receiver does from one cycle to the next. Two configuration bits choose the path. The select bit `sel_poll` picks the wake-up polling path when it is 1. The enable bit `slv_en` turns on the always-listening slave path when `sel_poll` is 0. Each path first passes through its own initialisation state, which lasts a fixed number of cycles. The block then settles in its working state.

On the slave path the receiver listens continuously. On the polling path it first searches periodically for a wake-up criterion. Once the criterion is found, it listens continuously until one of three events occurs. A timer timeout sends it back to polling. An end of message does the same, but only when `eom_poll_en` is set. Clearing `sel_poll` sends it back to sleep.

The six states and their 3-bit codes are: SLEEP (0), INIT_SLAVE (1), SLAVE_RUN (2), INIT_POLL (3), POLL (4) and POLL_RUN (5). The transitions are:
- sleep-to-init-slave: from SLEEP when `sel_poll`=0 and `slv_en`=1.
- sleep-to-init-poll: from SLEEP when `sel_poll`=1.
- init-slave-done and init-poll-done: from an initialisation state to its working state when the initialisation time has run out.
- slave-abort: from INIT_SLAVE or SLAVE_RUN to SLEEP.
- poll-abort: from INIT_POLL, POLL or POLL_RUN to SLEEP.
- wake-found: from POLL to POLL_RUN.
- timeout-return: from POLL_RUN to POLL on a timeout.
- eom-return: from POLL_RUN to POLL on an enabled end of message.

Top module: `rxm_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mode` is 0 (SLEEP) and both `init_strobe` and `rx_active` are 0. SLEEP stays put while `sel_poll`=0 and `slv_en`=0.
- R2: In SLEEP with `sel_poll`=0 and `slv_en`=1, the next clock edge moves `mode` to 1 (INIT_SLAVE).
- R3: An initialisation state (1 or 3) lasts exactly INIT_CYCLES clock cycles (default 4), unless its path is aborted. It then moves to 2 (SLAVE_RUN) from state 1, or to 4 (POLL) from state 3.
- R4: In state 1 or state 2, if `slv_en`=0 or `sel_poll`=1, the next edge moves `mode` to 0. Otherwise state 2 holds.
- R5: In SLEEP with `sel_poll`=1, the next edge moves `mode` to 3, whatever the value of `slv_en`.
- R6: In POLL with `sel_poll`=1, `wake_found`=1 moves `mode` to 5 and `wake_found`=0 keeps it at 4.
- R7: In POLL_RUN with `sel_poll`=1, a `timeout` pulse moves `mode` to 4. With neither a timeout nor an enabled end of message, it stays at 5.
- R8: In POLL_RUN with `sel_poll`=1, `eom`=1 moves `mode` to 4 when `eom_poll_en`=1, and leaves it at 5 when `eom_poll_en`=0.
- R9: In states 3, 4 or 5, `sel_poll`=0 moves `mode` to 0 on the next edge.
- R10: `init_strobe` is 1 exactly in states 1 and 3. `rx_active` is 1 exactly in states 2, 4 and 5.
- R11: Leaving a path because of the configuration bits takes precedence over every event input. A timeout takes precedence over an end of message in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_poll | input | 1 | Path select: 1 selects the polling path |
| slv_en | input | 1 | Slave reception enable, used when `sel_poll`=0 |
| timeout | input | 1 | Timer timeout pulse |
| wake_found | input | 1 | Wake-up criterion found |
| eom | input | 1 | End of message |
| eom_poll_en | input | 1 | Allows `eom` to return to polling |
| mode | output | 3 | Current state code (0..5) |
| init_strobe | output | 1 | High during initialisation |
| rx_active | output | 1 | Receive enable |

## Verification
Directed sequences cover the following cases:
- Each initialisation run, counted cycle by cycle, which separates the correct duration from a duration that is one cycle off in either direction.
- Entry to the polling path with `slv_en` both 0 and 1, which shows that the enable bit is ignored there.
- An end of message with `eom_poll_en` low and then high, which separates the gated return from an ungated one.
- A timeout and an end of message arriving together with `sel_poll` cleared, which shows that the configuration exit wins over both events.

Long constrained-random runs then use slowly changing configuration bits and frequent event pulses. Every state is visited and every transition is checked against a reference model in the bench, one cycle at a time.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP     = 3'd0,
        ST_INIT_SLV  = 3'd1,
        ST_SLV_RUN   = 3'd2,
        ST_INIT_POLL = 3'd3,
        ST_POLL      = 3'd4,
        ST_POLL_RUN  = 3'd5
    } rxm_state_e;

    typedef struct packed {
        logic sel_poll;
        logic slv_en;
        logic timeout;
        logic wake_found;
        logic eom;
        logic eom_poll_en;
    } rxm_in_t;
endpackage

// File: rtl/rxm_init_timer.sv
module rxm_init_timer #(
    parameter int INIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/rxm_next_state.sv
module rxm_next_state
    import rxm_pkg::*;
(
    input  rxm_state_e cur,
    input  rxm_in_t    cfg,
    input  logic       init_done,
    output rxm_state_e nxt
);
    logic slave_ok;
    logic poll_ok;
    logic back_to_poll;

    assign slave_ok     = !cfg.sel_poll && cfg.slv_en;
    assign poll_ok      = cfg.sel_poll;
    assign back_to_poll = cfg.timeout || (cfg.eom && cfg.eom_poll_en);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_SLEEP: begin
                if (cfg.sel_poll)  nxt = ST_INIT_POLL;
                else if (cfg.slv_en) nxt = ST_INIT_SLV;
                else nxt = ST_SLEEP;
            end
            ST_INIT_SLV: begin
                if (!slave_ok)      nxt = ST_SLEEP;
                else if (init_done) nxt = ST_SLV_RUN;
                else nxt = ST_INIT_SLV;
            end
            ST_SLV_RUN: begin
                nxt = slave_ok ? ST_SLV_RUN : ST_SLEEP;
            end
            ST_INIT_POLL: begin
                if (!poll_ok)       nxt = ST_SLEEP;
                else if (init_done) nxt = ST_POLL;
                else nxt = ST_INIT_POLL;
            end
            ST_POLL: begin
                if (!poll_ok)            nxt = ST_SLEEP;
                else if (cfg.wake_found) nxt = ST_POLL_RUN;
                else nxt = ST_POLL;
            end
            ST_POLL_RUN: begin
                if (!poll_ok)          nxt = ST_SLEEP;
                else if (back_to_poll) nxt = ST_POLL;
                else nxt = ST_POLL_RUN;
            end
            default: nxt = ST_SLEEP;
        endcase
    end
endmodule

// File: rtl/rxm_mode_ctrl.sv
module rxm_mode_ctrl
    import rxm_pkg::*;
#(
    parameter int INIT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_poll,
    input  logic       slv_en,
    input  logic       timeout,
    input  logic       wake_found,
    input  logic       eom,
    input  logic       eom_poll_en,
    output logic [2:0] mode,
    output logic       init_strobe,
    output logic       rx_active
);
    rxm_state_e state;
    rxm_state_e state_nxt;
    rxm_in_t    cfg;
    logic       in_init;
    logic       init_done;

    assign cfg = '{sel_poll: sel_poll, slv_en: slv_en, timeout: timeout,
                   wake_found: wake_found, eom: eom, eom_poll_en: eom_poll_en};

    assign in_init = (state == ST_INIT_SLV) || (state == ST_INIT_POLL);

    rxm_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_init),
        .done (init_done)
    );

    rxm_next_state u_next (
        .cur      (state),
        .cfg      (cfg),
        .init_done(init_done),
        .nxt      (state_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= state_nxt;
    end

    always_comb begin
        mode        = state;
        init_strobe = 1'b0;
        rx_active   = 1'b0;
        unique case (state)
            ST_SLEEP:     ;
            ST_INIT_SLV:  init_strobe = 1'b1;
            ST_SLV_RUN:   rx_active   = 1'b1;
            ST_INIT_POLL: init_strobe = 1'b1;
            ST_POLL:      rx_active   = 1'b1;
            ST_POLL_RUN:  rx_active   = 1'b1;
            default:      ;
        endcase
    end

    // R2
    sleep_to_init_slv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !sel_poll && slv_en) |=> mode == 3'd1);

    // R5
    sleep_to_init_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && sel_poll) |=> mode == 3'd3);

    // R4
    slave_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_INIT_SLV || state == ST_SLV_RUN) && (sel_poll || !slv_en))
        |=> mode == 3'd0);

    // R6
    poll_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && sel_poll && wake_found) |=> mode == 3'd5);

    // R7
    poll_run_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_RUN && sel_poll && timeout) |=> mode == 3'd4);

    // R8
    eom_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_RUN && sel_poll && !timeout && !eom_poll_en) |=> mode == 3'd5);

    // R9
    poll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_INIT_POLL || state == ST_POLL || state == ST_POLL_RUN) && !sel_poll)
        |=> mode == 3'd0);

    // R10
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_strobe, rx_active}));

    // R3
    init_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> ($past(init_strobe) || $past(mode) == 3'd4 || $past(mode) == 3'd5));
endmodule

// File: tb/rxm_mode_ctrl_bench.sv
module rxm_mode_ctrl_bench;
    localparam int INIT_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_poll = 1'b0, slv_en = 1'b0, timeout = 1'b0;
    logic       wake_found = 1'b0, eom = 1'b0, eom_poll_en = 1'b0;
    logic [2:0] mode;
    logic       init_strobe, rx_active;

    int checks = 0;
    int errors = 0;
    int exp_state = 0;
    int exp_age = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rxm_mode_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_rxm_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_poll(sel_poll), .slv_en(slv_en),
        .timeout(timeout), .wake_found(wake_found), .eom(eom),
        .eom_poll_en(eom_poll_en), .mode(mode), .init_strobe(init_strobe),
        .rx_active(rx_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            0: return sel_poll ? "R5" : (slv_en ? "R2" : "R1");
            1, 3: return ((s == 1) ? (sel_poll || !slv_en) : !sel_poll) ? ((s == 1) ? "R4" : "R9") : "R3";
            2: return "R4";
            4: return sel_poll ? "R6" : "R9";
            default: begin
                if (!sel_poll) return (timeout || eom) ? "R11" : "R9";
                if (timeout) return eom ? "R11" : "R7";
                if (eom) return "R8";
                return "R7";
            end
        endcase
    endfunction

    function automatic int next_of(int s, int age);
        bit done = (age == INIT_CYCLES - 1);
        case (s)
            0: return sel_poll ? 3 : (slv_en ? 1 : 0);
            1: return (sel_poll || !slv_en) ? 0 : (done ? 2 : 1);
            2: return (sel_poll || !slv_en) ? 0 : 2;
            3: return !sel_poll ? 0 : (done ? 4 : 3);
            4: return !sel_poll ? 0 : (wake_found ? 5 : 4);
            default: begin
                if (!sel_poll) return 0;
                if (timeout || (eom && eom_poll_en)) return 4;
                return 5;
            end
        endcase
    endfunction

    task automatic drive(bit ms, bit se, bit to, bit wk, bit eo, bit en);
        @(negedge clk);
        sel_poll = ms; slv_en = se; timeout = to; wake_found = wk; eom = eo; eom_poll_en = en;
    endtask

    task automatic step();
        string tag;
        int nxt;
        @(posedge clk);
        tag = tag_of(exp_state);
        nxt = next_of(exp_state, exp_age);
        exp_age = (nxt == exp_state && (nxt == 1 || nxt == 3)) ? exp_age + 1 : 0;
        exp_state = nxt;
        #1;
        chk(int'(mode) == exp_state, tag, int'(mode), exp_state);
        // R10
        chk(init_strobe == (exp_state == 1 || exp_state == 3), "R10", init_strobe,
            int'(exp_state == 1 || exp_state == 3));
        chk(rx_active == (exp_state == 2 || exp_state == 4 || exp_state == 5), "R10",
            rx_active, int'(exp_state == 2 || exp_state == 4 || exp_state == 5));
    endtask

    task automatic go(bit ms, bit se, bit to, bit wk, bit eo, bit en, int n);
        for (int i = 0; i < n; i++) begin
            drive(ms, se, to, wk, eo, en);
            step();
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int strobe_len;
        bit ms, se;
        void'($urandom(32'd1234));
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(mode == 3'd0, "R1", mode, 0);
        chk(!init_strobe && !rx_active, "R1", {init_strobe, rx_active}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        go(0, 0, 1, 1, 1, 1, 3);               // R1 idle stays
        // R2 and R3: slave path, count the strobe length
        drive(0, 1, 0, 0, 0, 0);
        step();
        strobe_len = 0;
        while (init_strobe && strobe_len < 20) begin
            strobe_len++;
            drive(0, 1, 0, 0, 0, 0);
            step();
        end
        chk(strobe_len == INIT_CYCLES, "R3", strobe_len, INIT_CYCLES);
        chk(mode == 3'd2, "R3", mode, 2);
        go(0, 1, 1, 1, 1, 1, 3);               // R4 holds
        go(0, 0, 0, 0, 0, 0, 1);               // R4 exit
        // R5: polling entry with slave enable set, abort slave init by sel_poll
        go(0, 1, 0, 0, 0, 0, 2);
        go(1, 1, 0, 0, 0, 0, 1);               // R4 exit from init
        go(1, 1, 0, 0, 0, 0, INIT_CYCLES + 1); // R5 then R3
        chk(mode == 3'd4, "R3", mode, 4);
        go(1, 0, 0, 0, 0, 0, 3);               // R6 stay
        go(1, 0, 0, 1, 0, 0, 1);               // R6 wake
        go(1, 0, 0, 0, 1, 0, 3);               // R8 gated off
        chk(mode == 3'd5, "R8", mode, 5);
        go(1, 0, 0, 0, 1, 1, 1);               // R8 enabled
        chk(mode == 3'd4, "R8", mode, 4);
        go(1, 0, 0, 1, 0, 0, 1);
        go(1, 0, 1, 0, 1, 0, 1);               // R7 / R11 timeout with eom
        chk(mode == 3'd4, "R7", mode, 4);
        go(1, 0, 0, 1, 0, 0, 1);
        go(0, 0, 1, 0, 1, 1, 1);               // R11 exit beats events
        chk(mode == 3'd0, "R11", mode, 0);
        // random phase
        ms = 1'b0; se = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) ms = ~ms;
            if ($urandom_range(0, 15) == 0) se = ~se;
            drive(ms, se, $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0,
                  $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1);
            step();
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule